// File: doc/BRIEF.md
# Multiply-Divide Unit with Operand-Dependent Busy Timing

This block holds a pair of 32-bit result registers, HI and LO, for an integer core. On a start strobe it performs signed or unsigned multiplication, signed or unsigned division, or a direct write of HI or LO. The arithmetic results are committed to HI and LO when the operation is accepted. The architectural latency is modelled by a busy counter that is loaded at the same moment.

Multiply latency depends on the magnitude of the first operand, and every divide costs a fixed number of cycles. A read of HI or LO while the counter is non-zero raises a stall until the counter drains, and only then may the value be consumed. Division by zero and the single signed overflow case give fixed results and never trap. A new operation accepted while the unit is busy reloads the counter with its own latency.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO are zero, and a read request does not stall.
- R2: Operation code 0 (signed multiply) sign-extends both operands and writes the low 32 bits of the 64-bit product to LO and the high 32 bits to HI.
- R3: Operation code 1 (unsigned multiply) zero-extends both operands and splits the product the same way.
- R4: After an unsigned multiply, the unit is busy for 7 + (2 - floor(z/11)) * 4 cycles, where z is the leading-zero count of (a | 1). This gives 7, 11 or 15 cycles.
- R5: A signed multiply uses the same latency formula, with z taken from (a XOR (a arithmetically shifted right by 21)) | 1.
- R6: Operation codes 2 (signed divide) and 3 (unsigned divide) keep the unit busy for 37 cycles.
- R7: A signed divide with a non-zero divisor, outside the overflow case, writes the quotient truncated toward zero to LO. It writes the remainder to HI, and the remainder carries the sign of the dividend.
- R8: A signed divide by zero writes the dividend to HI. LO becomes 0xFFFFFFFF for a non-negative dividend and 1 for a negative dividend.
- R9: A signed divide of 0x80000000 by 0xFFFFFFFF writes 0x80000000 to LO and 0 to HI.
- R10: An unsigned divide writes the quotient to LO and the remainder to HI. A zero divisor instead gives LO = 0xFFFFFFFF and HI = the dividend.
- R11: stall_o is high exactly when rd_req_i is high and the busy count is non-zero. rd_data_o shows LO when rd_sel_i is 0 and HI when rd_sel_i is 1.
- R12: Operation codes 4 (write HI from a_i) and 5 (write LO from a_i) take effect at the next edge. They leave the other register untouched and neither reload nor clear the busy count.
- R13: An operation of codes 0 to 3 accepted while busy restarts the busy count from its own latency.
- R14: Operation codes 6 and 7 change neither HI, LO nor the busy count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept the operation on op_i this cycle |
| op_i | input | 3 | Operation code (see R2 to R14) |
| a_i | input | 32 | First operand: multiplicand, dividend or value to write |
| b_i | input | 32 | Second operand: multiplier or divisor |
| rd_req_i | input | 1 | Request to read HI or LO |
| rd_sel_i | input | 1 | 0 selects LO, 1 selects HI |
| stall_o | output | 1 | Read must wait; the unit is busy |
| rd_data_o | output | 32 | Selected register value |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |

## Verification
The checker checks every cycle that a stall only appears with a read request and that the unit is still busy one cycle after any multiply or divide. It also checks that HI and LO hold steady when no operation is accepted, that direct writes and unsigned division by zero land in the right register, and that an idle unit stays idle without a new start. The exact busy length of each magnitude bucket, the divide quotient and remainder signs, the restart of the counter mid-divide and a direct write during a divide can only be shown by the bench's scenarios. The bench measures those stall lengths and compares them with a model it keeps.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   localparam logic [2:0] OP_MULS = 3'd0;
   localparam logic [2:0] OP_MULU = 3'd1;
   localparam logic [2:0] OP_DIVS = 3'd2;
   localparam logic [2:0] OP_DIVU = 3'd3;
   localparam logic [2:0] OP_WRHI = 3'd4;
   localparam logic [2:0] OP_WRLO = 3'd5;

   // codes 0..3 run the arithmetic and load the busy counter
   function automatic logic op_is_arith(input logic [2:0] op);
      return !op[2];
   endfunction
endpackage

// File: rtl/muldiv_latency.sv
module muldiv_latency
   import muldiv_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MUL_BASE   = 7,
   parameter int MUL_STEP   = 4,
   parameter int MUL_BUCKET = 11,
   parameter int SIGN_SHIFT = 21,
   parameter int DIV_CYCLES = 37,
   parameter int CNT_W      = 6
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   output logic [CNT_W-1:0]  lat_o
);
   localparam int LZ_W = $clog2(DATA_W) + 1;
   localparam int NB   = (DATA_W - 1) / MUL_BUCKET;

   logic [DATA_W-1:0] a_sra;
   logic [DATA_W-1:0] probe;
   logic [LZ_W-1:0]   lz;
   logic              found;

   assign a_sra = $unsigned($signed(a_i) >>> SIGN_SHIFT);
   assign probe = ((op_i == OP_MULS) ? (a_i ^ a_sra) : a_i) | DATA_W'(1);

   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (!found) begin
            if (probe[i]) found = 1'b1;
            else          lz    = lz + LZ_W'(1);
         end
      end
   end

   always_comb begin
      if (op_i[2])      lat_o = '0;
      else if (op_i[1]) lat_o = CNT_W'(DIV_CYCLES);
      else              lat_o = CNT_W'(MUL_BASE + (NB - int'(lz) / MUL_BUCKET) * MUL_STEP);
   end
endmodule

// File: rtl/muldiv_arith.sv
module muldiv_arith
   import muldiv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] lo_o,
   output logic              wr_hi_o,
   output logic              wr_lo_o
);
   localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] ALL_ONE = '1;

   logic [2*DATA_W-1:0] prod_s, prod_u;

   assign prod_s = $unsigned($signed({{DATA_W{a_i[DATA_W-1]}}, a_i}) *
                             $signed({{DATA_W{b_i[DATA_W-1]}}, b_i}));
   assign prod_u = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};

   always_comb begin
      hi_o    = '0;
      lo_o    = '0;
      wr_hi_o = 1'b0;
      wr_lo_o = 1'b0;
      case (op_i)
         OP_MULS: begin
            {hi_o, lo_o} = prod_s;
            wr_hi_o = 1'b1;
            wr_lo_o = 1'b1;
         end
         OP_MULU: begin
            {hi_o, lo_o} = prod_u;
            wr_hi_o = 1'b1;
            wr_lo_o = 1'b1;
         end
         OP_DIVS: begin
            wr_hi_o = 1'b1;
            wr_lo_o = 1'b1;
            if (b_i == '0) begin
               hi_o = a_i;
               lo_o = a_i[DATA_W-1] ? DATA_W'(1) : ALL_ONE;
            end else if (a_i == MIN_NEG && b_i == ALL_ONE) begin
               hi_o = '0;
               lo_o = MIN_NEG;
            end else begin
               lo_o = $unsigned($signed(a_i) / $signed(b_i));
               hi_o = $unsigned($signed(a_i) % $signed(b_i));
            end
         end
         OP_DIVU: begin
            wr_hi_o = 1'b1;
            wr_lo_o = 1'b1;
            if (b_i == '0) begin
               hi_o = a_i;
               lo_o = ALL_ONE;
            end else begin
               lo_o = a_i / b_i;
               hi_o = a_i % b_i;
            end
         end
         OP_WRHI: begin
            hi_o    = a_i;
            wr_hi_o = 1'b1;
         end
         OP_WRLO: begin
            lo_o    = a_i;
            wr_lo_o = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/muldiv_busy.sv
module muldiv_busy #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] lat_i,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= lat_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MUL_BASE   = 7,
   parameter int MUL_STEP   = 4,
   parameter int MUL_BUCKET = 11,
   parameter int SIGN_SHIFT = 21,
   parameter int DIV_CYCLES = 37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              rd_req_i,
   input  logic              rd_sel_i,
   output logic              stall_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] lo_o
);
   localparam int NB      = (DATA_W - 1) / MUL_BUCKET;
   localparam int MUL_MAX = MUL_BASE + NB * MUL_STEP;
   localparam int LAT_MAX = (MUL_MAX > DIV_CYCLES) ? MUL_MAX : DIV_CYCLES;
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("muldiv_unit: DATA_W must be at least 2");
      end
      if (MUL_BASE < 1 || DIV_CYCLES < 1) begin : g_bad_lat
         $error("muldiv_unit: latencies must be at least 1");
      end
      if (MUL_BUCKET < 1 || SIGN_SHIFT >= DATA_W) begin : g_bad_bucket
         $error("muldiv_unit: bad bucket or shift parameter");
      end
   endgenerate

   logic [CNT_W-1:0]  lat;
   logic [DATA_W-1:0] hi_n, lo_n;
   logic              wr_hi, wr_lo, busy;
   logic [DATA_W-1:0] hi_q, lo_q;

   muldiv_latency #(
      .DATA_W(DATA_W), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP),
      .MUL_BUCKET(MUL_BUCKET), .SIGN_SHIFT(SIGN_SHIFT),
      .DIV_CYCLES(DIV_CYCLES), .CNT_W(CNT_W)
   ) u_lat (
      .op_i(op_i), .a_i(a_i), .lat_o(lat)
   );

   muldiv_arith #(.DATA_W(DATA_W)) u_arith (
      .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .hi_o(hi_n), .lo_o(lo_n), .wr_hi_o(wr_hi), .wr_lo_o(wr_lo)
   );

   muldiv_busy #(.CNT_W(CNT_W)) u_busy (
      .clk(clk), .rst_n(rst_n),
      .load_i(start_i && op_is_arith(op_i)),
      .lat_i(lat), .busy_o(busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (start_i) begin
         if (wr_hi) hi_q <= hi_n;
         if (wr_lo) lo_q <= lo_n;
      end
   end

   assign hi_o      = hi_q;
   assign lo_o      = lo_q;
   assign stall_o   = rd_req_i && busy;
   assign rd_data_o = rd_sel_i ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_unit_checker.sv
module muldiv_unit_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic              rd_req_i,
   input logic              stall_o,
   input logic [DATA_W-1:0] hi_o,
   input logic [DATA_W-1:0] lo_o
);
   assert_stall_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> rd_req_i);

   assert_div_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (op_i == 3'd2 || op_i == 3'd3)) |=> (!rd_req_i || stall_o));

   assert_mul_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (op_i == 3'd0 || op_i == 3'd1)) |=> (!rd_req_i || stall_o));

   assert_divu_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd3 && b_i == '0) |=> (lo_o == '1 && hi_o == $past(a_i)));

   assert_write_hi_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd4) |=> (hi_o == $past(a_i) && $stable(lo_o)));

   assert_write_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd5) |=> (lo_o == $past(a_i) && $stable(hi_o)));

   assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i || op_i[2:1] == 2'b11) |=> ($stable(hi_o) && $stable(lo_o)));

   assert_idle_stays_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && !stall_o && (!start_i || op_i[2])) |=> !stall_o);
endmodule

bind muldiv_unit muldiv_unit_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
   .a_i(a_i), .b_i(b_i), .rd_req_i(rd_req_i), .stall_o(stall_o),
   .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [31:0] a_i = '0, b_i = '0;
   logic        rd_req_i = 1'b0, rd_sel_i = 1'b0;
   logic        stall_o;
   logic [31:0] rd_data_o, hi_o, lo_o;

   int n_chk = 0, n_fail = 0;
   bit [31:0] m_hi = '0, m_lo = '0;

   always #2.5 clk = ~clk;

   muldiv_unit u_muldiv_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
      .stall_o(stall_o), .rd_data_o(rd_data_o), .hi_o(hi_o), .lo_o(lo_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int lzc(input bit [31:0] x);
      for (int i = 31; i >= 0; i--) if (x[i]) return 31 - i;
      return 32;
   endfunction

   function automatic int exp_lat(input bit [2:0] op, input bit [31:0] a);
      bit [31:0] s;
      if (op == 3'd2 || op == 3'd3) return 37;
      if (op == 3'd1) return 7 + (2 - lzc(a | 32'd1) / 11) * 4;
      if (op == 3'd0) begin
         s = a[31] ? ~(~a >> 21) : (a >> 21);
         return 7 + (2 - lzc((a ^ s) | 32'd1) / 11) * 4;
      end
      return 0;
   endfunction

   // update the bench model of HI and LO for one accepted operation
   task automatic model(input bit [2:0] op, input bit [31:0] a, input bit [31:0] b);
      longint sa, sb, q, r;
      bit [63:0] p;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (op)
         3'd0: begin p = 64'(sa * sb); m_hi = p[63:32]; m_lo = p[31:0]; end
         3'd1: begin p = {32'd0, a} * {32'd0, b}; m_hi = p[63:32]; m_lo = p[31:0]; end
         3'd2: begin
            if (b == 0) begin m_hi = a; m_lo = a[31] ? 32'd1 : 32'hFFFF_FFFF; end
            else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin m_hi = 0; m_lo = a; end
            else begin q = sa / sb; r = sa - q * sb; m_lo = q[31:0]; m_hi = r[31:0]; end
         end
         3'd3: begin
            if (b == 0) begin m_hi = a; m_lo = 32'hFFFF_FFFF; end
            else begin m_lo = a / b; m_hi = a % b; end
         end
         3'd4: m_hi = a;
         3'd5: m_lo = a;
         default: ;
      endcase
   endtask

   task automatic count_stall(output int n);
      n = 0;
      while (stall_o && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_regs(input string req);
      rd_sel_i = 1'b0; #0.1;
      check(rd_data_o == m_lo, {req, " LO"}, rd_data_o, m_lo);
      rd_sel_i = 1'b1; #0.1;
      check(rd_data_o == m_hi && hi_o == m_hi, {req, " HI"}, rd_data_o, m_hi);
      rd_sel_i = 1'b0;
   endtask

   task automatic run_op(input bit [2:0] op, input bit [31:0] a, input bit [31:0] b, input string req);
      int n, e;
      string lreq;
      e = exp_lat(op, a);
      lreq = (op == 3'd0) ? "R5 latency" : (op == 3'd1) ? "R4 latency" :
             (op < 3'd4) ? "R6 latency" : "R14/R12 latency";
      model(op, a, b);
      @(negedge clk);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b; rd_req_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; rd_req_i = 1'b1; rd_sel_i = 1'b0;
      #0.1;
      count_stall(n);
      check(n == e, lreq, n, e);
      check_regs(req);
   endtask

   initial begin
      #500000;
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      bit [31:0] ra, rb;
      bit [2:0] rop;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_req_i = 1'b1;
      #0.1;
      // R1: reset state
      check(!stall_o, "R1 stall", stall_o, 0);
      check(hi_o == 0 && lo_o == 0, "R1 regs", {hi_o, lo_o}, 0);

      // directed multiplies (R2, R3, R4, R5)
      run_op(3'd1, 32'd5, 32'd3, "R3");
      run_op(3'd1, 32'h0000_1234, 32'hFFFF_FFFF, "R3");
      run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
      run_op(3'd0, 32'hFFFF_FFFF, 32'd7, "R2");
      run_op(3'd0, 32'hFFFF_F000, 32'h0001_0000, "R2");
      run_op(3'd0, 32'h0040_0000, 32'h8000_0000, "R2");
      run_op(3'd0, 32'h8000_0000, 32'h8000_0000, "R2");
      run_op(3'd0, 32'h0000_0400, 32'd9, "R2");

      // directed divides (R7, R8, R9, R10)
      run_op(3'd2, 32'hFFFF_FFF9, 32'd2, "R7");
      run_op(3'd2, 32'd7, 32'hFFFF_FFFE, "R7");
      run_op(3'd2, 32'd100, 32'd0, "R8");
      run_op(3'd2, 32'hFFFF_FF00, 32'd0, "R8");
      run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R9");
      run_op(3'd3, 32'hFFFF_FFFF, 32'd10, "R10");
      run_op(3'd3, 32'h1234_5678, 32'd0, "R10");

      // direct writes and ignored codes (R12, R14)
      run_op(3'd4, 32'hCAFE_0001, 32'd0, "R12");
      run_op(3'd5, 32'hBEEF_0002, 32'd0, "R12");
      run_op(3'd6, 32'h1111_1111, 32'd3, "R14");
      run_op(3'd7, 32'h2222_2222, 32'd0, "R14");

      // R13: restart a divide with a short multiply
      model(3'd2, 32'd1000, 32'd3);
      @(negedge clk); start_i = 1'b1; op_i = 3'd2; a_i = 32'd1000; b_i = 32'd3; rd_req_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      model(3'd1, 32'd5, 32'd3);
      @(negedge clk); start_i = 1'b1; op_i = 3'd1; a_i = 32'd5; b_i = 32'd3;
      @(negedge clk); start_i = 1'b0; rd_req_i = 1'b1; #0.1;
      count_stall(n);
      check(n == 7, "R13 restart", n, 7);
      check_regs("R13");

      // R12: direct write of LO during a divide keeps the count running
      model(3'd3, 32'd100, 32'd7);
      @(negedge clk); start_i = 1'b1; op_i = 3'd3; a_i = 32'd100; b_i = 32'd7; rd_req_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      model(3'd5, 32'h0000_ABCD, 32'd0);
      start_i = 1'b1; op_i = 3'd5; a_i = 32'h0000_ABCD;
      @(negedge clk); start_i = 1'b0; rd_req_i = 1'b1; #0.1;
      count_stall(n);
      check(n == 34, "R12 count kept", n, 34);
      check_regs("R12 mid-divide");

      // R11: stall only with a request
      @(negedge clk); start_i = 1'b1; op_i = 3'd3; a_i = 32'd9; b_i = 32'd2; rd_req_i = 1'b0;
      model(3'd3, 32'd9, 32'd2);
      @(negedge clk); start_i = 1'b0; #0.1;
      check(!stall_o, "R11 no request", stall_o, 0);
      rd_req_i = 1'b1; #0.1;
      check(stall_o, "R11 request busy", stall_o, 1);
      count_stall(n);
      check_regs("R11");

      // constrained random mix
      for (int k = 0; k < 40; k++) begin
         rop = 3'($urandom_range(0, 5));
         case ($urandom_range(0, 3))
            0: ra = $urandom;
            1: ra = $urandom_range(0, 255);
            2: ra = 32'hFFFF_FFFF - $urandom_range(0, 255);
            default: ra = $urandom >> $urandom_range(0, 31);
         endcase
         rb = ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom >> $urandom_range(0, 31);
         run_op(rop, ra, rb, (rop < 3'd2) ? "R2/R3 random" : (rop < 3'd4) ? "R7/R10 random" : "R12 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule